// File: doc/BRIEF.md
# Programmable Sample-Clock Timebase with Slow External Clock Monitor

This block derives an internal sampling clock from a 100 MHz reference by dividing it down to one of a ladder of periods. The periods run in a 1-2-5 pattern from two reference cycles (20 ns) up to fifty million cycles (500 ms) at the default setting. The processor picks the period, and picks internal or external sampling, by writing a six-bit selection word. Any accepted write restarts the divider, so the output never shows a shortened pulse after a change. In external mode the output follows the external sampling clock after a synchronizer instead.

A free-running interval timer raises an interrupt request to the processor at a fixed period (10 ms by default). The request stays up until the processor pulses its status-read strobe. In external mode a gap monitor counts reference cycles between external rising edges. It raises a slow-clock flag once the gap reaches its limit (25 ms by default), and the next external rising edge drops the flag.

Top module: `sample_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, `sampleClk`, `irqReq` and `slowClk` are all low after that edge, and the selection resets to code 0 in internal mode.
- R2: On a clock edge with `wrEn` high, bits 4:0 of `wrData` become the period code and bit 5 becomes the mode (1 = external, 0 = internal). With `wrEn` low, `wrData` has no effect on `sampleClk`.
- R3: In internal mode, code c (0 to 3*MAX_EXP+1) selects a period of m*10^e reference cycles, where m is 2, 5 or 1 for c mod 3 equal to 0, 1 or 2, and e = floor((c+1)/3). Each period begins with a rising edge of `sampleClk` and keeps it high for floor(period/2) cycles.
- R4: Every code above 3*MAX_EXP+1 selects the slowest period.
- R5: After the edge that accepts a write selecting internal mode, `sampleClk` is low and its first rising edge comes exactly one full new period of edges later.
- R6: `irqReq` becomes high on edge number k*TIMER_CYCLES after reset release (k >= 1, edges counted from 1), whatever the selection.
- R7: `rdStatus` high at an edge clears `irqReq` after that edge, unless that edge is also a timer edge; in that case the request stays high.
- R8: A request still pending at a later timer edge stays high and is not counted twice: one status read clears it, and it stays low until the next timer edge.
- R9: In external mode `sampleClk` takes the level `extClk` held before an edge three edges later.
- R10: In external mode `slowClk` rises on the SLOW_LIMIT-th edge after the third edge that follows a rising edge of `extClk`, if no further rising edge occurs, and stays high while none arrives. In internal mode `slowClk` is low.
- R11: A rising edge of `extClk` clears a high `slowClk` on the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the selection word |
| wrData | input | 6 | Selection word: [4:0] period code, [5] external mode |
| rdStatus | input | 1 | Status-read strobe, clears the interrupt request |
| extClk | input | 1 | External sampling clock, asynchronous |
| sampleClk | output | 1 | Selected sampling clock |
| irqReq | output | 1 | Interval-timer interrupt request |
| slowClk | output | 1 | Slow external clock flag |

## Verification
Each result has a fixed edge count after its stimulus. The divider's first rising edge comes exactly one period of edges after the write edge. The external level reaches `sampleClk` on the third edge. The interrupt request is set on multiples of the timer interval and drops one edge after a read. The slow flag changes on the third edge after an external rise and again SLOW_LIMIT edges later. The bench drives inputs and samples outputs on falling edges and counts rising edges from the write, the reset release or the external transition. It compares every cycle of a divider window against a waveform computed from the period formula, and it tracks the interrupt request each cycle with a model that applies the set-wins rule.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Strobes and mode the control sends to the datapath each cycle
  typedef struct packed {
    logic restartDiv;  // accepted selection write this cycle
    logic extEdge;     // synchronized rising edge of the external clock
    logic useExt;      // mode that is in force after this edge
  } tbStrobe_t;

  // Divider period in reference cycles for a 5-bit code. Codes past the
  // last valid one fold onto the slowest setting.
  function automatic int unsigned periodFor(input int unsigned code,
                                            input int unsigned maxExp);
    int unsigned lastCode;
    int unsigned c;
    int unsigned p;
    int unsigned e;
    lastCode = 3 * maxExp + 1;
    c = (code > lastCode) ? lastCode : code;
    case (c % 3)
      0:       p = 2;
      1:       p = 5;
      default: p = 1;
    endcase
    e = (c + 1) / 3;
    for (int unsigned i = 0; i < 10; i++) begin
      if (i < e) p = p * 10;
    end
    return p;
  endfunction

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
#(
  parameter int unsigned MAX_EXP      = 7,
  parameter int unsigned TIMER_CYCLES = 1_000_000,
  parameter int unsigned PER_W        = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [5:0]       wrData,
  input  logic             rdStatus,
  input  logic             extClk,
  output tbStrobe_t        strb,
  output logic [PER_W-1:0] period,
  output logic             extLevel,
  output logic             irqReq
);

  localparam int unsigned TK_W = (TIMER_CYCLES > 1) ? $clog2(TIMER_CYCLES) : 1;
  localparam logic [TK_W-1:0] TICK_LAST = TK_W'(TIMER_CYCLES - 1);
  localparam logic [PER_W-1:0] RESET_PERIOD = PER_W'(periodFor(0, MAX_EXP));

  // Selection register: decoded period plus mode
  logic             extSelQ;
  logic [PER_W-1:0] perQ;
  logic [PER_W-1:0] perDecoded;

  assign perDecoded = PER_W'(periodFor(32'(wrData[4:0]), MAX_EXP));

  always_ff @(posedge clk) begin
    if (rst) begin
      extSelQ <= 1'b0;
      perQ    <= RESET_PERIOD;
    end else if (wrEn) begin
      extSelQ <= wrData[5];
      perQ    <= perDecoded;
    end
  end

  // External clock synchronizer and rising-edge detect
  logic syncA, syncB, syncC;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= extClk;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  always_comb begin
    strb.restartDiv = wrEn;
    strb.extEdge    = syncB & ~syncC;
    strb.useExt     = wrEn ? wrData[5] : extSelQ;
  end

  assign period   = perQ;
  assign extLevel = syncB;

  // Interval timer and interrupt request
  logic [TK_W-1:0] tickCnt;
  logic            tick;
  logic            irqQ;

  assign tick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // A tick wins over a read in the same cycle; a pending request absorbs
  // further ticks.
  always_ff @(posedge clk) begin
    if (rst) begin
      irqQ <= 1'b0;
    end else if (tick) begin
      irqQ <= 1'b1;
    end else if (rdStatus) begin
      irqQ <= 1'b0;
    end
  end

  assign irqReq = irqQ;

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    tickCnt <= TICK_LAST);  // R6
  AST_TICK_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
    tick |=> irqReq);  // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rdStatus && !tick) |=> !irqReq);  // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irqReq && !rdStatus) |=> irqReq);  // R8
  AST_PERIOD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (period == $past(perDecoded)));  // R2

endmodule

// File: rtl/tbase_datapath.sv
module tbase_datapath
  import tbase_pkg::*;
#(
  parameter int unsigned PER_W      = 26,
  parameter int unsigned SLOW_LIMIT = 2_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  tbStrobe_t        strb,
  input  logic [PER_W-1:0] period,
  input  logic             extLevel,
  output logic             sampleClk,
  output logic             slowClk
);

  localparam int unsigned GAP_W = $clog2(SLOW_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(SLOW_LIMIT);

  // Divider: counter, first-period holdoff and output level
  logic [PER_W-1:0] divCnt, divCntNext, halfPer;
  logic             firstPer, firstNext;
  logic             wrapNow;
  logic             divLevelNext;
  logic             outQ;

  assign halfPer = period >> 1;
  assign wrapNow = (divCnt == period - 1'b1);

  always_comb begin
    if (strb.restartDiv) begin
      divCntNext = '0;
      firstNext  = 1'b1;
    end else if (wrapNow) begin
      divCntNext = '0;
      firstNext  = 1'b0;
    end else begin
      divCntNext = divCnt + 1'b1;
      firstNext  = firstPer;
    end
    divLevelNext = ~firstNext & (divCntNext < halfPer);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= '0;
      firstPer <= 1'b1;
      outQ     <= 1'b0;
    end else begin
      divCnt   <= divCntNext;
      firstPer <= firstNext;
      outQ     <= strb.useExt ? extLevel : divLevelNext;
    end
  end

  assign sampleClk = outQ;

  // Gap monitor on the external clock
  logic [GAP_W-1:0] gapCnt;
  logic             modeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= '0;
      modeQ  <= 1'b0;
    end else begin
      modeQ <= strb.useExt;
      if (!strb.useExt || strb.extEdge) begin
        gapCnt <= '0;
      end else if (gapCnt != GAP_TOP) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  assign slowClk = modeQ & (gapCnt == GAP_TOP);

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    divCnt < period);  // R3
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    (strb.restartDiv && !strb.useExt) |=> (!sampleClk && divCnt == '0));  // R5
  AST_GAP_SATURATES: assert property (@(posedge clk) disable iff (rst)
    gapCnt <= GAP_TOP);  // R10
  AST_NO_FLAG_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    !strb.useExt |=> !slowClk);  // R10
  AST_EDGE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    strb.extEdge |=> !slowClk);  // R11

endmodule

// File: rtl/sample_timebase.sv
module sample_timebase
  import tbase_pkg::*;
#(
  parameter int unsigned MAX_EXP      = 7,
  parameter int unsigned TIMER_CYCLES = 1_000_000,
  parameter int unsigned SLOW_LIMIT   = 2_500_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [5:0] wrData,
  input  logic       rdStatus,
  input  logic       extClk,
  output logic       sampleClk,
  output logic       irqReq,
  output logic       slowClk
);

  localparam int unsigned MAX_PERIOD = periodFor(31, MAX_EXP);
  localparam int unsigned PER_W      = $clog2(MAX_PERIOD + 1);

  tbStrobe_t        strb;
  logic [PER_W-1:0] period;
  logic             extLevel;

  tbase_ctrl #(
    .MAX_EXP      (MAX_EXP),
    .TIMER_CYCLES (TIMER_CYCLES),
    .PER_W        (PER_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdStatus (rdStatus),
    .extClk   (extClk),
    .strb     (strb),
    .period   (period),
    .extLevel (extLevel),
    .irqReq   (irqReq)
  );

  tbase_datapath #(
    .PER_W      (PER_W),
    .SLOW_LIMIT (SLOW_LIMIT)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .period    (period),
    .extLevel  (extLevel),
    .sampleClk (sampleClk),
    .slowClk   (slowClk)
  );

endmodule

// File: tb/tb_sample_timebase.sv
module tb_sample_timebase;

  localparam int MAX_EXP = 2;
  localparam int TCYC    = 400;
  localparam int SLOW    = 600;
  localparam int LAST    = 3 * MAX_EXP + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [5:0] wrData = '0;
  logic       rdStatus = 1'b0;
  logic       extClk = 1'b0;
  logic       sampleClk, irqReq, slowClk;

  always #5 clk = ~clk;

  sample_timebase #(
    .MAX_EXP(MAX_EXP), .TIMER_CYCLES(TCYC), .SLOW_LIMIT(SLOW)
  ) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdStatus(rdStatus),
    .extClk(extClk), .sampleClk(sampleClk), .irqReq(irqReq), .slowClk(slowClk)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic irqModel = 1'b0;
  int irqMism = 0;
  int irqSamples = 0;

  // Period from R3/R4: mantissa 2,5,1 by code mod 3, exponent (code+1)/3
  function automatic int periodRef(int code);
    int c, m, p;
    c = (code > LAST) ? LAST : code;
    m = (c % 3 == 0) ? 2 : ((c % 3 == 1) ? 5 : 1);
    p = m;
    for (int i = 0; i < (c + 1) / 3; i++) p = p * 10;
    return p;
  endfunction

  // Expected level k edges after an accepted write (R3, R5)
  function automatic logic divExpect(int k, int p);
    if (k < p) return 1'b0;
    return ((k - p) % p) < (p / 2);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Interrupt model from R6/R7/R8: edges counted from reset release
  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0;
      irqModel <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if ((cyc + 1) % TCYC == 0) irqModel <= 1'b1;
      else if (rdStatus) irqModel <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      irqSamples++;
      if (irqReq !== irqModel) irqMism++;
    end
  end

  task automatic writeSel(bit ext, int code);
    wrEn = 1'b1;
    wrData = {ext, 5'(code)};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkDiv(int code, string tag, bit randRead);
    int p, mism, firstRise;
    p = periodRef(code);
    writeSel(1'b0, code);
    mism = 0;
    firstRise = -1;
    for (int k = 0; k <= 3 * p; k++) begin
      if (sampleClk !== divExpect(k, p)) mism++;
      if (firstRise < 0 && sampleClk === 1'b1) firstRise = k;
      rdStatus = randRead ? ($urandom % 40 == 0) : 1'b0;
      @(negedge clk);
    end
    rdStatus = 1'b0;
    check(firstRise == p, "R5", $sformatf("first rise after write, code %0d", code), firstRise, p);
    check(mism == 0, tag, $sformatf("waveform mismatches, code %0d", code), mism, 0);
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL all: watchdog expired, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedVal;
    int p, mism;
    seedVal = $urandom(32'd7741);

    // R1 reset state
    repeat (3) @(negedge clk);
    check(sampleClk === 1'b0, "R1", "sampleClk in reset", int'(sampleClk), 0);
    check(irqReq === 1'b0, "R1", "irqReq in reset", int'(irqReq), 0);
    check(slowClk === 1'b0, "R1", "slowClk in reset", int'(slowClk), 0);
    rst = 1'b0;

    // R1: reset selection is code 0, period 2
    @(negedge clk);
    mism = 0;
    for (int k = 1; k <= 12; k++) begin
      if (sampleClk !== divExpect(k, 2)) mism++;
      @(negedge clk);
    end
    check(mism == 0, "R1", "code 0 waveform after reset", mism, 0);

    // R6 first tick
    while (cyc < TCYC - 1) @(negedge clk);
    check(irqReq === 1'b0, "R6", "irq before first interval", int'(irqReq), 0);
    @(negedge clk);
    check(irqReq === 1'b1, "R6", "irq at first interval", int'(irqReq), 1);

    // R7 read clears
    rdStatus = 1'b1;
    @(negedge clk);
    rdStatus = 1'b0;
    check(irqReq === 1'b0, "R7", "irq after read", int'(irqReq), 0);

    // R7 read on the tick edge: set wins
    while ((cyc % TCYC) != TCYC - 1) @(negedge clk);
    rdStatus = 1'b1;
    @(negedge clk);
    rdStatus = 1'b0;
    check(irqReq === 1'b1, "R7", "read coinciding with tick", int'(irqReq), 1);

    // R8 pending across a tick, one read clears, no second request
    @(negedge clk);
    while ((cyc % TCYC) != 0) @(negedge clk);
    check(irqReq === 1'b1, "R8", "pending across tick", int'(irqReq), 1);
    rdStatus = 1'b1;
    @(negedge clk);
    rdStatus = 1'b0;
    check(irqReq === 1'b0, "R8", "single read clears", int'(irqReq), 0);
    while ((cyc % TCYC) != TCYC - 1) @(negedge clk);
    check(irqReq === 1'b0, "R8", "no queued request", int'(irqReq), 0);

    // R3 every valid code
    for (int c = 0; c <= LAST; c++) checkDiv(c, "R3", 1'b0);

    // R4 unused codes
    checkDiv(LAST + 1, "R4", 1'b0);
    checkDiv(31, "R4", 1'b0);

    // R5 rewrite in the middle of a long period
    writeSel(1'b0, 5);
    repeat (37) @(negedge clk);
    checkDiv(2, "R5", 1'b0);

    // R2 data without a write strobe has no effect
    p = periodRef(3);
    writeSel(1'b0, 3);
    wrData = 6'h3F;
    mism = 0;
    for (int k = 0; k <= 4 * p; k++) begin
      if (sampleClk !== divExpect(k, p)) mism++;
      @(negedge clk);
    end
    check(mism == 0, "R2", "wrData ignored without wrEn", mism, 0);

    // Random codes with random status reads (R3, R4, R7)
    for (int n = 0; n < 25; n++) begin
      int code;
      code = $urandom % 32;
      checkDiv(code, (code > LAST) ? "R4" : "R3", 1'b1);
    end

    // R9 external mode latency
    writeSel(1'b1, 0);
    extClk = 1'b1;
    repeat (2) @(negedge clk);
    check(sampleClk === 1'b0, "R9", "ext rise after 2 edges", int'(sampleClk), 0);
    @(negedge clk);
    check(sampleClk === 1'b1, "R9", "ext rise after 3 edges", int'(sampleClk), 1);
    extClk = 1'b0;
    repeat (2) @(negedge clk);
    check(sampleClk === 1'b1, "R9", "ext fall after 2 edges", int'(sampleClk), 1);
    @(negedge clk);
    check(sampleClk === 1'b0, "R9", "ext fall after 3 edges", int'(sampleClk), 0);

    // R10 slow flag timing
    extClk = 1'b1;
    repeat (3) @(negedge clk);
    check(slowClk === 1'b0, "R10", "flag just after edge", int'(slowClk), 0);
    repeat (SLOW - 1) @(negedge clk);
    check(slowClk === 1'b0, "R10", "flag one edge before limit", int'(slowClk), 0);
    @(negedge clk);
    check(slowClk === 1'b1, "R10", "flag at limit", int'(slowClk), 1);
    extClk = 1'b0;
    repeat (50) @(negedge clk);
    check(slowClk === 1'b1, "R10", "flag held without rising edge", int'(slowClk), 1);

    // R11 next rising edge clears
    extClk = 1'b1;
    repeat (2) @(negedge clk);
    check(slowClk === 1'b1, "R11", "flag two edges after rise", int'(slowClk), 1);
    @(negedge clk);
    check(slowClk === 1'b0, "R11", "flag three edges after rise", int'(slowClk), 0);

    // R10 internal mode never flags
    writeSel(1'b0, 3);
    check(slowClk === 1'b0, "R10", "flag after leaving ext mode", int'(slowClk), 0);
    repeat (SLOW + 20) @(negedge clk);
    check(slowClk === 1'b0, "R10", "flag in internal mode", int'(slowClk), 0);

    // R6 R7 R8 tracked every cycle
    check(irqMism == 0 && irqSamples > 0, "R6", "irq cycle tracking (R7 R8)", irqMism, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule